// File: doc/BRIEF.md
# Two-Sided Processor Message Exchange Unit

This block sits between two processors, called side A and side B, and lets them pass 32-bit words and data-less notifications to each other. Each side has its own register-mapped port with a byte address, a write strobe, a read strobe and combinational read data. Both sides see the same register map. A word written into one of a side's four outbound slots appears in the matching inbound slot of the other side. A pair of flags tracks each slot: the sender sees an "outbound slot free" flag and the receiver sees an "inbound slot loaded" flag.

Next to the data slots there are four doorbells per direction. A side raises a request bit in its control register. The bit reaches the other side as a sticky pending flag, and the receiver clears that flag by writing a one to it. Each side has one interrupt output. It is the OR of every status flag that has its enable bit set in that side's control register. Channel bits are packed four to a nibble in reversed order: channel 0 takes the highest bit of its nibble.

Software on each side polls or takes interrupts. It writes outbound words, reads inbound words (the read strobe consumes the slot), and rings or acknowledges doorbells.

Top module: `xproc_msg_unit`

## Requirements
- R1: After reset, status reads 0x00F00000 on both sides (all outbound-free flags set, nothing loaded, nothing pending). Control reads 0 and both interrupt outputs are low.
- R2: A write by side A to byte offset 4*n (n = 0..3) stores the word. Side B then reads it at offset 0x10+4*n. From the cycle after the write, A's outbound-free flag n reads 0 and B's inbound-loaded flag n reads 1.
- R3: A read strobe on inbound offset 0x10+4*n clears the reader's inbound-loaded flag n and sets the writer's outbound-free flag n from the next cycle on.
- R4: The same transfer and flags work from side B to side A.
- R5: Status is at offset 0x20. Channel n has its pending flag at bit 28+(3-n), inbound-loaded at bit 24+(3-n) and outbound-free at bit 20+(3-n). All other status bits read 0.
- R6: Control is at offset 0x24. Writing 1 to control bit 16+(3-n) sets the request bit, which reads back as 1 for one cycle. At the next edge it sets the other side's pending flag n and clears itself. A second notification needs a new write.
- R7: Writing 1 to a pending bit in status clears it. Writing 0 leaves it unchanged. Writes to every other status bit are ignored. A new request arriving in the same cycle as the clear wins.
- R8: A side's interrupt is high while any status flag is set together with its enable in control. The enables are pending enable at bit 28+(3-n), inbound-loaded enable at 24+(3-n) and outbound-free enable at 20+(3-n).
- R9: Control bits 31:20 read back as written. Writes to the inbound offsets 0x10..0x1C are ignored.
- R10: Writing an outbound slot that is still loaded replaces the word, and the loaded flag stays set.
- R11: If the sender writes slot n in the same cycle as the receiver reads it, the read returns the old word and the slot stays loaded with the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe (consumes inbound slots) |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data for a_addr |
| a_irq | output | 1 | Side A interrupt |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe (consumes inbound slots) |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data for b_addr |
| b_irq | output | 1 | Side B interrupt |

## Verification
Words are sent in both directions on several channels, including the first and last slot, so that a swapped direction or a wrong nibble position shows up in the status values. Overwrites of a loaded slot and a write that collides with a read in the same cycle separate the set-wins priority from a clear-wins one. Doorbells are checked for the one-cycle request readback and the arrival of the pending flag. Pending bits are cleared both with a zero write and with a write to all the non-pending bits, which shows that only ones on pending bits have any effect. Each of the three interrupt sources is enabled alone and its flag is toggled, which shows that the interrupt follows the flag and its own enable only.

// File: rtl/xmu_pkg.sv
package xmu_pkg;
   localparam int unsigned REG_W  = 32;
   localparam int unsigned SLOTS  = 4;
   localparam int unsigned W_RX0  = 4;
   localparam int unsigned W_STAT = 8;
   localparam int unsigned W_CTRL = 9;
   localparam int unsigned GP_LSB = 28;
   localparam int unsigned RF_LSB = 24;
   localparam int unsigned TE_LSB = 20;
   localparam int unsigned GR_LSB = 16;

   typedef logic [REG_W-1:0] word_t;

   // channel bits are reversed inside their nibble
   function automatic int unsigned slot_bit(int unsigned lsb, int unsigned ch);
      return lsb + (SLOTS - 1 - ch);
   endfunction
endpackage

// File: rtl/xmu_lane.sv
module xmu_lane
   import xmu_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  logic  take,
   input  word_t din,
   output word_t dout,
   output logic  full
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         full <= 1'b0;
      end else begin
         if (load) dout <= din;
         full <= load | (full & ~take);
      end
   end
endmodule

// File: rtl/xmu_bell.sv
module xmu_bell #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req_set,
   input  logic [NUM_CH-1:0] pend_clr,
   output logic [NUM_CH-1:0] req_q,
   output logic [NUM_CH-1:0] pend_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         pend_q <= '0;
      end else begin
         req_q  <= req_set;
         pend_q <= (pend_q & ~pend_clr) | req_q;
      end
   end
endmodule

// File: rtl/xmu_port.sv
module xmu_port
   import xmu_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic                         rd_en,
   input  logic [ADDR_W-1:0]            addr,
   input  word_t                        wdata,
   output word_t                        rdata,
   output logic                         irq,
   input  logic [NUM_CH-1:0][REG_W-1:0] tx_word,
   input  logic [NUM_CH-1:0][REG_W-1:0] rx_word,
   input  logic [NUM_CH-1:0]            tx_busy,
   input  logic [NUM_CH-1:0]            rx_full,
   input  logic [NUM_CH-1:0]            gp_pend,
   input  logic [NUM_CH-1:0]            gp_req,
   output logic [NUM_CH-1:0]            tx_load,
   output logic [NUM_CH-1:0]            rx_take,
   output logic [NUM_CH-1:0]            req_set,
   output logic [NUM_CH-1:0]            pend_clr
);
   localparam int unsigned WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              ctrl_wr;
   logic              stat_wr;
   logic [NUM_CH-1:0] gie_q;
   logic [NUM_CH-1:0] rie_q;
   logic [NUM_CH-1:0] tie_q;
   word_t             stat_w;
   word_t             ctrl_w;
   logic              unused_bits;

   assign word        = addr[ADDR_W-1:2];
   assign ctrl_wr     = wr_en && (word == WORD_W'(W_CTRL));
   assign stat_wr     = wr_en && (word == WORD_W'(W_STAT));
   assign unused_bits = ^{addr[1:0], wdata[15:0]};

   always_comb begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
         tx_load[ch]  = wr_en && (word == WORD_W'(ch));
         rx_take[ch]  = rd_en && (word == WORD_W'(W_RX0 + ch));
         req_set[ch]  = ctrl_wr && wdata[slot_bit(GR_LSB, ch)];
         pend_clr[ch] = stat_wr && wdata[slot_bit(GP_LSB, ch)];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q <= '0;
         rie_q <= '0;
         tie_q <= '0;
      end else if (ctrl_wr) begin
         for (int ch = 0; ch < NUM_CH; ch++) begin
            gie_q[ch] <= wdata[slot_bit(GP_LSB, ch)];
            rie_q[ch] <= wdata[slot_bit(RF_LSB, ch)];
            tie_q[ch] <= wdata[slot_bit(TE_LSB, ch)];
         end
      end
   end

   always_comb begin
      stat_w = '0;
      ctrl_w = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         stat_w[slot_bit(GP_LSB, ch)] = gp_pend[ch];
         stat_w[slot_bit(RF_LSB, ch)] = rx_full[ch];
         stat_w[slot_bit(TE_LSB, ch)] = ~tx_busy[ch];
         ctrl_w[slot_bit(GP_LSB, ch)] = gie_q[ch];
         ctrl_w[slot_bit(RF_LSB, ch)] = rie_q[ch];
         ctrl_w[slot_bit(TE_LSB, ch)] = tie_q[ch];
         ctrl_w[slot_bit(GR_LSB, ch)] = gp_req[ch];
      end
   end

   always_comb begin
      rdata = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         if (word == WORD_W'(ch))         rdata = tx_word[ch];
         if (word == WORD_W'(W_RX0 + ch)) rdata = rx_word[ch];
      end
      if (word == WORD_W'(W_STAT)) rdata = stat_w;
      if (word == WORD_W'(W_CTRL)) rdata = ctrl_w;
   end

   assign irq = (|(gp_pend & gie_q)) | (|(rx_full & rie_q)) | (|(~tx_busy & tie_q));
endmodule

// File: rtl/xproc_msg_unit.sv
module xproc_msg_unit
   import xmu_pkg::*;
#(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned ADDR_W   = 6,
   parameter bit          IRQ_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_wr_en,
   input  logic              a_rd_en,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [REG_W-1:0]  a_wdata,
   output logic [REG_W-1:0]  a_rdata,
   output logic              a_irq,
   input  logic              b_wr_en,
   input  logic              b_rd_en,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [REG_W-1:0]  b_wdata,
   output logic [REG_W-1:0]  b_rdata,
   output logic              b_irq
);
   if (NUM_CH < 1 || NUM_CH > SLOTS) begin : g_bad_ch
      $error("NUM_CH must be between 1 and 4");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must cover offsets up to 0x24");
   end

   logic [NUM_CH-1:0][REG_W-1:0] ab_data;
   logic [NUM_CH-1:0][REG_W-1:0] ba_data;
   logic [NUM_CH-1:0] ab_full, ba_full;
   logic [NUM_CH-1:0] ab_gir, ba_gir;
   logic [NUM_CH-1:0] a_pend, b_pend;
   logic [NUM_CH-1:0] a_tx_load, a_rx_take, a_req_set, a_pend_clr;
   logic [NUM_CH-1:0] b_tx_load, b_rx_take, b_req_set, b_pend_clr;
   logic              a_irq_raw, b_irq_raw;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
      xmu_lane u_ab (
         .clk(clk), .rst_n(rst_n), .load(a_tx_load[ch]), .take(b_rx_take[ch]),
         .din(a_wdata), .dout(ab_data[ch]), .full(ab_full[ch])
      );
      xmu_lane u_ba (
         .clk(clk), .rst_n(rst_n), .load(b_tx_load[ch]), .take(a_rx_take[ch]),
         .din(b_wdata), .dout(ba_data[ch]), .full(ba_full[ch])
      );
   end

   xmu_bell #(.NUM_CH(NUM_CH)) u_bell_ab (
      .clk(clk), .rst_n(rst_n), .req_set(a_req_set), .pend_clr(b_pend_clr),
      .req_q(ab_gir), .pend_q(b_pend)
   );
   xmu_bell #(.NUM_CH(NUM_CH)) u_bell_ba (
      .clk(clk), .rst_n(rst_n), .req_set(b_req_set), .pend_clr(a_pend_clr),
      .req_q(ba_gir), .pend_q(a_pend)
   );

   xmu_port #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_port_a (
      .clk(clk), .rst_n(rst_n), .wr_en(a_wr_en), .rd_en(a_rd_en), .addr(a_addr),
      .wdata(a_wdata), .rdata(a_rdata), .irq(a_irq_raw),
      .tx_word(ab_data), .rx_word(ba_data), .tx_busy(ab_full), .rx_full(ba_full),
      .gp_pend(a_pend), .gp_req(ab_gir),
      .tx_load(a_tx_load), .rx_take(a_rx_take), .req_set(a_req_set), .pend_clr(a_pend_clr)
   );
   xmu_port #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_port_b (
      .clk(clk), .rst_n(rst_n), .wr_en(b_wr_en), .rd_en(b_rd_en), .addr(b_addr),
      .wdata(b_wdata), .rdata(b_rdata), .irq(b_irq_raw),
      .tx_word(ba_data), .rx_word(ab_data), .tx_busy(ba_full), .rx_full(ab_full),
      .gp_pend(b_pend), .gp_req(ba_gir),
      .tx_load(b_tx_load), .rx_take(b_rx_take), .req_set(b_req_set), .pend_clr(b_pend_clr)
   );

   if (IRQ_FLOP) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_irq <= 1'b0;
            b_irq <= 1'b0;
         end else begin
            a_irq <= a_irq_raw;
            b_irq <= b_irq_raw;
         end
      end
   end else begin : g_irq_comb
      assign a_irq = a_irq_raw;
      assign b_irq = b_irq_raw;
   end
endmodule

// File: rtl/xmu_checker.sv
module xmu_checker #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              a_wr_en,
   input logic              a_rd_en,
   input logic [ADDR_W-1:0] a_addr,
   input logic [31:0]       a_wdata,
   input logic              b_wr_en,
   input logic              b_rd_en,
   input logic [ADDR_W-1:0] b_addr,
   input logic [31:0]       b_wdata,
   input logic [NUM_CH-1:0] ab_full,
   input logic [NUM_CH-1:0] ba_full,
   input logic [NUM_CH-1:0] ab_gir,
   input logic [NUM_CH-1:0] b_pend
);
   localparam int unsigned WW = ADDR_W - 2;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      a_r2_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
         (a_wr_en && a_addr[ADDR_W-1:2] == WW'(ch)) |=> ab_full[ch]);

      a_r4_load_sets_full_back: assert property (@(posedge clk) disable iff (!rst_n)
         (b_wr_en && b_addr[ADDR_W-1:2] == WW'(ch)) |=> ba_full[ch]);

      a_r3_take_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
         (b_rd_en && b_addr[ADDR_W-1:2] == WW'(4 + ch)
          && !(a_wr_en && a_addr[ADDR_W-1:2] == WW'(ch))) |=> !ab_full[ch]);

      a_r6_req_reaches_pend: assert property (@(posedge clk) disable iff (!rst_n)
         ab_gir[ch] |=> b_pend[ch]);

      a_r6_req_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (ab_gir[ch] && !(a_wr_en && a_addr[ADDR_W-1:2] == WW'(9) && a_wdata[16 + 3 - ch]))
         |=> !ab_gir[ch]);

      a_r7_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (b_pend[ch] && !(b_wr_en && b_addr[ADDR_W-1:2] == WW'(8) && b_wdata[28 + 3 - ch]))
         |=> b_pend[ch]);
   end
endmodule

bind xproc_msg_unit xmu_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata),
   .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata),
   .ab_full(ab_full), .ba_full(ba_full), .ab_gir(ab_gir), .b_pend(b_pend)
);

// File: tb/xproc_msg_unit_bench.sv
module xproc_msg_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        drv_wr [2];
   logic        drv_rd [2];
   logic [5:0]  drv_addr [2];
   logic [31:0] drv_wdata [2];
   logic [31:0] rdata_w [2];
   logic        irq_w [2];

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   // behavioural reference state: index [sender] for lanes and requests
   logic [31:0] m_data [2][4];
   bit          m_full [2][4];
   bit [11:0]   m_en   [2];
   bit          m_gir  [2][4];
   bit          m_pend [2][4];

   always #4 clk = ~clk;

   xproc_msg_unit u_xproc_msg_unit (
      .clk(clk), .rst_n(rst_n),
      .a_wr_en(drv_wr[0]), .a_rd_en(drv_rd[0]), .a_addr(drv_addr[0]),
      .a_wdata(drv_wdata[0]), .a_rdata(rdata_w[0]), .a_irq(irq_w[0]),
      .b_wr_en(drv_wr[1]), .b_rd_en(drv_rd[1]), .b_addr(drv_addr[1]),
      .b_wdata(drv_wdata[1]), .b_rdata(rdata_w[1]), .b_irq(irq_w[1])
   );

   function automatic logic [31:0] m_status(int s);
      logic [31:0] v = '0;
      for (int n = 0; n < 4; n++) begin
         v[28 + 3 - n] = m_pend[s][n];
         v[24 + 3 - n] = m_full[1 - s][n];
         v[20 + 3 - n] = !m_full[s][n];
      end
      return v;
   endfunction

   function automatic logic [31:0] m_read(int s, logic [5:0] ad);
      int w = int'(ad[5:2]);
      logic [31:0] v = '0;
      if (w < 4) v = m_data[s][w];
      else if (w < 8) v = m_data[1 - s][w - 4];
      else if (w == 8) v = m_status(s);
      else if (w == 9) begin
         v[31:20] = m_en[s];
         for (int n = 0; n < 4; n++) v[16 + 3 - n] = m_gir[s][n];
      end
      return v;
   endfunction

   function automatic logic m_irq(int s);
      logic [31:0] st = m_status(s);
      return |(st[31:20] & m_en[s]);
   endfunction

   task automatic model_reset();
      for (int s = 0; s < 2; s++) begin
         m_en[s] = '0;
         for (int n = 0; n < 4; n++) begin
            m_data[s][n] = '0; m_full[s][n] = 0; m_gir[s][n] = 0; m_pend[s][n] = 0;
         end
      end
   endtask

   task automatic model_update();
      bit old_full [2][4];
      bit old_gir [2][4];
      for (int s = 0; s < 2; s++)
         for (int n = 0; n < 4; n++) begin
            old_full[s][n] = m_full[s][n]; old_gir[s][n] = m_gir[s][n];
         end
      for (int s = 0; s < 2; s++) begin
         int o = 1 - s;
         int ws = int'(drv_addr[s][5:2]);
         int wo = int'(drv_addr[o][5:2]);
         for (int n = 0; n < 4; n++) begin
            bit ld = drv_wr[s] && ws == n;
            bit tk = drv_rd[o] && wo == 4 + n;
            m_full[s][n] = ld || (old_full[s][n] && !tk);
            if (ld) m_data[s][n] = drv_wdata[s];
            m_gir[s][n] = drv_wr[s] && ws == 9 && drv_wdata[s][16 + 3 - n];
            m_pend[s][n] = (m_pend[s][n] && !(drv_wr[s] && ws == 8 && drv_wdata[s][28 + 3 - n]))
                           || old_gir[o][n];
         end
         if (drv_wr[s] && ws == 9) m_en[s] = drv_wdata[s][31:20];
      end
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic idle();
      for (int s = 0; s < 2; s++) begin
         drv_wr[s] = 0; drv_rd[s] = 0; drv_addr[s] = '0; drv_wdata[s] = '0;
      end
   endtask

   // one cycle: compare against the model, take the edge, advance the model
   task automatic step();
      #1;
      for (int s = 0; s < 2; s++) begin
         chk($sformatf("R5/R9 model rdata side %0d", s), rdata_w[s], m_read(s, drv_addr[s]));
         chk($sformatf("R8 model irq side %0d", s), {31'b0, irq_w[s]}, {31'b0, m_irq(s)});
      end
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic wr(int s, logic [5:0] ad, logic [31:0] d);
      drv_wr[s] = 1; drv_addr[s] = ad; drv_wdata[s] = d;
      step();
      idle();
   endtask

   task automatic rd_chk(int s, logic [5:0] ad, logic [31:0] exp, string req);
      drv_rd[s] = 1; drv_addr[s] = ad;
      #1 chk(req, rdata_w[s], exp);
      step();
      idle();
   endtask

   task automatic irq_chk(int s, logic exp, string req);
      #1 chk(req, {31'b0, irq_w[s]}, {31'b0, exp});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      idle();
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk(0, 6'h20, 32'h00F0_0000, "R1 A status");
      rd_chk(1, 6'h20, 32'h00F0_0000, "R1 B status");
      rd_chk(0, 6'h24, 32'h0, "R1 A control");
      irq_chk(0, 1'b0, "R1 A irq");
      irq_chk(1, 1'b0, "R1 B irq");

      // R2 / R5 A to B on channel 1
      wr(0, 6'h04, 32'hDEAD_BEEF);
      rd_chk(0, 6'h20, 32'h00B0_0000, "R2 R5 A free flag 1 cleared");
      rd_chk(1, 6'h20, 32'h04F0_0000, "R2 R5 B loaded flag 1 set");
      rd_chk(1, 6'h14, 32'hDEAD_BEEF, "R2 B inbound word 1");
      // R3 read consumed the slot
      rd_chk(1, 6'h20, 32'h00F0_0000, "R3 B loaded flag cleared");
      rd_chk(0, 6'h20, 32'h00F0_0000, "R3 A free flag set");

      // R4 B to A on channel 3
      wr(1, 6'h0C, 32'h1234_5678);
      rd_chk(0, 6'h20, 32'h01F0_0000, "R4 R5 A loaded flag 3");
      rd_chk(1, 6'h20, 32'h00E0_0000, "R4 R5 B free flag 3 cleared");
      rd_chk(0, 6'h1C, 32'h1234_5678, "R4 A inbound word 3");

      // R10 overwrite while loaded
      wr(0, 6'h00, 32'h0000_1111);
      wr(0, 6'h00, 32'h0000_2222);
      rd_chk(1, 6'h20, 32'h08F0_0000, "R10 loaded flag stays set");
      rd_chk(1, 6'h10, 32'h0000_2222, "R10 newest word kept");

      // R11 write and read in the same cycle
      wr(0, 6'h08, 32'h0000_5555);
      drv_wr[0] = 1; drv_addr[0] = 6'h08; drv_wdata[0] = 32'h0000_AAAA;
      drv_rd[1] = 1; drv_addr[1] = 6'h18;
      #1 chk("R11 collision read returns old word", rdata_w[1], 32'h0000_5555);
      step();
      idle();
      rd_chk(1, 6'h20, 32'h02F0_0000, "R11 slot stays loaded");
      rd_chk(1, 6'h18, 32'h0000_AAAA, "R11 new word present");

      // R6 doorbell A to B channel 1
      wr(0, 6'h24, 32'h0004_0000);
      rd_chk(0, 6'h24, 32'h0004_0000, "R6 request visible one cycle");
      rd_chk(0, 6'h24, 32'h0, "R6 request self-cleared");
      rd_chk(1, 6'h20, 32'h40F0_0000, "R6 R5 B pending 1");

      // R7 write-one-to-clear
      wr(1, 6'h20, 32'h0);
      rd_chk(1, 6'h20, 32'h40F0_0000, "R7 zero write keeps pending");
      wr(1, 6'h20, 32'h0FFF_FFFF);
      rd_chk(1, 6'h20, 32'h40F0_0000, "R7 other status bits ignored");
      wr(1, 6'h20, 32'h4000_0000);
      rd_chk(1, 6'h20, 32'h00F0_0000, "R7 pending cleared");

      // R8 pending interrupt
      wr(1, 6'h24, 32'h4000_0000);
      irq_chk(1, 1'b0, "R8 enabled but no pending");
      wr(0, 6'h24, 32'h0004_0000);
      step();
      irq_chk(1, 1'b1, "R8 pending raises irq");
      wr(1, 6'h20, 32'h4000_0000);
      irq_chk(1, 1'b0, "R8 cleared pending drops irq");
      wr(1, 6'h24, 32'h0);

      // R8 outbound-free interrupt
      wr(0, 6'h24, 32'h0080_0000);
      irq_chk(0, 1'b1, "R8 free flag with enable");
      wr(0, 6'h00, 32'h0000_0077);
      irq_chk(0, 1'b0, "R8 slot busy drops irq");
      rd_chk(1, 6'h10, 32'h0000_0077, "R2 channel 0 word");
      irq_chk(0, 1'b1, "R8 slot freed raises irq");
      wr(0, 6'h24, 32'h0);

      // R8 inbound-loaded interrupt, R9 readback and ignored inbound write
      wr(1, 6'h24, 32'h0100_0000);
      rd_chk(1, 6'h24, 32'h0100_0000, "R9 control readback");
      irq_chk(1, 1'b0, "R8 nothing loaded");
      wr(0, 6'h0C, 32'h0000_0099);
      irq_chk(1, 1'b1, "R8 loaded slot raises irq");
      wr(1, 6'h1C, 32'hFFFF_FFFF);
      rd_chk(1, 6'h20, 32'h01F0_0000, "R9 inbound write leaves status");
      rd_chk(1, 6'h1C, 32'h0000_0099, "R9 inbound write ignored");
      irq_chk(1, 1'b0, "R8 consumed slot drops irq");
      wr(1, 6'h24, 32'h0);

      repeat (2) step();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule